// File: doc/BRIEF.md
# Level-Zero Veto Trigger Decision Unit

This block takes one event candidate per clock and decides whether the candidate passes the first trigger level. Each candidate brings four kinds of input. The first is a count of hits in the scintillator hodoscope. The second is one flag from the muon veto. The third is a 14-pocket hit mask from the large-angle photon veto. The fourth is a set of eight calorimeter octant energies, each in units of 0.1 GeV.

The unit sums the octant energies into a total. It also pairs the octants into quadrants in two ways, the second pairing rotated by 45 degrees from the first. For each pairing it counts the quadrants that hold a significant deposit. From these results it computes six condition bits and a single accept strobe.

The decision comes out a fixed two clocks after the candidate goes in, so an upstream sequencer can match each decision to its candidate by counting cycles. The trigger word keeps every individual condition result, and downstream logic stores it with the event data.

Top module: `l0_veto_trigger`

## Requirements
- R1: Trigger word bit 0 (hodoscope present) is 1 exactly when the hodoscope hit count is at least one.
- R2: Trigger word bit 1 (single track) is 1 exactly when the hodoscope hit count equals one.
- R3: Trigger word bit 2 (muon clear) is 1 exactly when the muon-veto flag is low.
- R4: Trigger word bit 3 (photon veto clear) is 1 exactly when none of the 14 pocket bits is set. Every pocket position, including bit 0 and bit 13, rejects the event on its own.
- R5: Trigger word bit 4 (energy ok) is 1 exactly when the sum of the eight octant energies is strictly below 500 (50.0 GeV). A sum of 499 passes and a sum of 500 fails.
- R6: A quadrant is active only when its sum is strictly above 10 (1.0 GeV), so a quadrant sum of exactly 10 is inactive. Partition A pairs octants {0,1}, {2,3}, {4,5} and {6,7}. Partition B pairs octants {1,2}, {3,4}, {5,6} and {7,0}. Octant i occupies bits [10*i+9 : 10*i] of the energy input.
- R7: Trigger word bit 5 (quadrant ok) is 1 when partition A or partition B, or both, has at most one active quadrant.
- R8: The accept output is 1 exactly when the output is valid and all six trigger word bits are 1.
- R9: The output valid, accept and word for a candidate appear two clock edges after the edge that samples it with the input valid high. Back-to-back candidates are accepted on every cycle.
- R10: A synchronous reset clears both pipeline stages. After a reset edge the output valid, accept and word read 0, even if a candidate was in flight.
- R11: While the output valid is low, the trigger word and the accept output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A candidate is present on the inputs this cycle |
| in_hodo_cnt | input | 4 | Hodoscope hit count |
| in_muon_hit | input | 1 | Muon veto fired |
| in_lav_mask | input | 14 | Large-angle photon veto pocket hits, one bit per pocket |
| in_octant_energy | input | 80 | Eight octant energies, 10 bits each in 0.1 GeV, octant 0 in the low bits |
| out_valid | output | 1 | Decision present, two cycles after its candidate |
| out_accept | output | 1 | Candidate passes every condition |
| out_word | output | 6 | Condition results: hodoscope present, single track, muon clear, photon veto clear, energy ok, quadrant ok (bit 0 upward) |

## Verification
Some properties are checked on every cycle. These are the two-cycle alignment of the output valid with the input valid, the clearing of the outputs after reset, and the zero word and accept while no decision is valid. The accept is checked to equal the AND of the word bits. The hodoscope, muon and photon veto bits are checked against the inputs sampled two cycles earlier. The energy and quadrant bits depend on summed arithmetic, so only the bench scenarios show them. Those scenarios cover the totals 499 and 500, a quadrant sum of exactly 10, and events where only one of the two partitions passes.

// File: rtl/l0_trig_pkg.sv
package l0_trig_pkg;

    localparam int TW_BITS = 6;

    localparam int BIT_HODO_PRESENT = 0;
    localparam int BIT_SINGLE_TRACK = 1;
    localparam int BIT_MUON_CLEAR   = 2;
    localparam int BIT_PHOTON_CLEAR = 3;
    localparam int BIT_ENERGY_OK    = 4;
    localparam int BIT_QUADRANT_OK  = 5;

    typedef logic [TW_BITS-1:0] tword_t;

endpackage

// File: rtl/l0_energy_sum.sv
// Total calorimeter energy plus the two quadrant partitions (R5, R6).
module l0_energy_sum #(
    parameter int OCTANTS = 8,
    parameter int E_W     = 10,
    parameter int QS_W    = E_W + 1,
    parameter int TOT_W   = E_W + $clog2(OCTANTS)
) (
    input  logic [OCTANTS*E_W-1:0]       oct_energy,
    output logic [TOT_W-1:0]             total,
    output logic [(OCTANTS/2)*QS_W-1:0]  quad_a,
    output logic [(OCTANTS/2)*QS_W-1:0]  quad_b
);
    localparam int NQ = OCTANTS / 2;

    always_comb begin
        total = '0;
        for (int i = 0; i < OCTANTS; i++) begin
            total = total + TOT_W'(oct_energy[i*E_W +: E_W]);
        end
    end

    // Partition A: even octant with its upper neighbour.
    // Partition B: the same pairing shifted by one octant (45 degrees).
    for (genvar q = 0; q < NQ; q++) begin : g_quad
        assign quad_a[q*QS_W +: QS_W] =
            QS_W'(oct_energy[(2*q)*E_W +: E_W]) +
            QS_W'(oct_energy[(2*q+1)*E_W +: E_W]);
        assign quad_b[q*QS_W +: QS_W] =
            QS_W'(oct_energy[(2*q+1)*E_W +: E_W]) +
            QS_W'(oct_energy[((2*q+2) % OCTANTS)*E_W +: E_W]);
    end

endmodule

// File: rtl/l0_quad_count.sv
// Counts quadrants whose sum is strictly above the threshold (R6, R7).
module l0_quad_count #(
    parameter int NQ    = 4,
    parameter int QS_W  = 11,
    parameter int THR   = 10,
    parameter int CNT_W = $clog2(NQ + 1)
) (
    input  logic [NQ*QS_W-1:0] sums,
    output logic [CNT_W-1:0]   n_active,
    output logic               at_most_one
);
    localparam logic [QS_W-1:0] THR_V = QS_W'(THR);

    logic [NQ-1:0] active;

    for (genvar q = 0; q < NQ; q++) begin : g_cmp
        assign active[q] = sums[q*QS_W +: QS_W] > THR_V;
    end

    always_comb begin
        n_active = '0;
        for (int i = 0; i < NQ; i++) begin
            n_active = n_active + CNT_W'(active[i]);
        end
        at_most_one = n_active <= CNT_W'(1);
    end

endmodule

// File: rtl/l0_veto_trigger.sv
// Two-stage trigger decision: stage 1 registers sums and veto summaries,
// stage 2 registers the trigger word and accept.
module l0_veto_trigger
    import l0_trig_pkg::*;
#(
    parameter int HODO_W       = 4,
    parameter int LAV_N        = 14,
    parameter int OCTANTS      = 8,
    parameter int E_W          = 10,
    parameter int ENERGY_LIMIT = 500,
    parameter int QUAD_THR     = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [HODO_W-1:0]      in_hodo_cnt,
    input  logic                   in_muon_hit,
    input  logic [LAV_N-1:0]       in_lav_mask,
    input  logic [OCTANTS*E_W-1:0] in_octant_energy,
    output logic                   out_valid,
    output logic                   out_accept,
    output logic [TW_BITS-1:0]     out_word
);
    localparam int NQ    = OCTANTS / 2;
    localparam int QS_W  = E_W + 1;
    localparam int TOT_W = E_W + $clog2(OCTANTS);
    localparam int CNT_W = $clog2(NQ + 1);
    localparam logic [TOT_W-1:0] LIMIT_V = TOT_W'(ENERGY_LIMIT);

    typedef struct packed {
        logic                 s1_valid;
        logic [HODO_W-1:0]    s1_hodo;
        logic                 s1_muon;
        logic                 s1_lav_any;
        logic [TOT_W-1:0]     s1_total;
        logic [NQ*QS_W-1:0]   s1_qa;
        logic [NQ*QS_W-1:0]   s1_qb;
        logic                 o_valid;
        logic                 o_accept;
        tword_t               o_word;
    } state_t;

    state_t state_d, state_q;

    logic [TOT_W-1:0]   total_w;
    logic [NQ*QS_W-1:0] qa_w, qb_w;
    logic [CNT_W-1:0]   na_a, na_b;
    logic               ok_a, ok_b;

    l0_energy_sum #(
        .OCTANTS (OCTANTS),
        .E_W     (E_W),
        .QS_W    (QS_W),
        .TOT_W   (TOT_W)
    ) i_sum (
        .oct_energy (in_octant_energy),
        .total      (total_w),
        .quad_a     (qa_w),
        .quad_b     (qb_w)
    );

    l0_quad_count #(
        .NQ    (NQ),
        .QS_W  (QS_W),
        .THR   (QUAD_THR),
        .CNT_W (CNT_W)
    ) i_cnt_a (
        .sums        (state_q.s1_qa),
        .n_active    (na_a),
        .at_most_one (ok_a)
    );

    l0_quad_count #(
        .NQ    (NQ),
        .QS_W  (QS_W),
        .THR   (QUAD_THR),
        .CNT_W (CNT_W)
    ) i_cnt_b (
        .sums        (state_q.s1_qb),
        .n_active    (na_b),
        .at_most_one (ok_b)
    );

    always_comb begin
        tword_t bits;
        state_d = state_q;

        // Stage 1: capture candidate summaries.
        state_d.s1_valid   = in_valid;
        state_d.s1_hodo    = in_hodo_cnt;
        state_d.s1_muon    = in_muon_hit;
        state_d.s1_lav_any = |in_lav_mask;
        state_d.s1_total   = total_w;
        state_d.s1_qa      = qa_w;
        state_d.s1_qb      = qb_w;

        // Stage 2: condition bits.
        bits = '0;
        bits[BIT_HODO_PRESENT] = state_q.s1_hodo != '0;
        bits[BIT_SINGLE_TRACK] = state_q.s1_hodo == HODO_W'(1);
        bits[BIT_MUON_CLEAR]   = !state_q.s1_muon;
        bits[BIT_PHOTON_CLEAR] = !state_q.s1_lav_any;
        bits[BIT_ENERGY_OK]    = state_q.s1_total < LIMIT_V;
        bits[BIT_QUADRANT_OK]  = ok_a || ok_b;

        state_d.o_valid  = state_q.s1_valid;
        state_d.o_word   = state_q.s1_valid ? bits : '0;
        state_d.o_accept = state_q.s1_valid && (&bits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.o_valid;
    assign out_accept = state_q.o_accept;
    assign out_word   = state_q.o_word;

endmodule

// File: rtl/l0_veto_trigger_chk.sv
module l0_veto_trigger_chk #(
    parameter int HODO_W = 4,
    parameter int LAV_N  = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [HODO_W-1:0] in_hodo_cnt,
    input logic              in_muon_hit,
    input logic [LAV_N-1:0]  in_lav_mask,
    input logic              out_valid,
    input logic              out_accept,
    input logic [5:0]        out_word
);
    // Cycles since reset, saturating; two are needed before $past(...,2) is meaningful.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    logic warm;
    assign warm = warm_q >= 2'd2;

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 2)));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_accept && out_word == 6'd0));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_word == 6'd0 && !out_accept));

    assert_accept_all_R8: assert property (@(posedge clk) disable iff (rst)
        out_accept |-> (out_valid && (&out_word)));

    assert_accept_needed_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (&out_word)) |-> out_accept);

    assert_single_has_hit_R2: assert property (@(posedge clk) disable iff (rst)
        out_word[1] |-> out_word[0]);

    assert_hodo_present_R1: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> (out_word[0] == ($past(in_hodo_cnt, 2) != '0)));

    assert_muon_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> (out_word[2] == !$past(in_muon_hit, 2)));

    assert_photon_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> (out_word[3] == ($past(in_lav_mask, 2) == '0)));

endmodule

bind l0_veto_trigger l0_veto_trigger_chk #(
    .HODO_W (HODO_W),
    .LAV_N  (LAV_N)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_hodo_cnt (in_hodo_cnt),
    .in_muon_hit (in_muon_hit),
    .in_lav_mask (in_lav_mask),
    .out_valid   (out_valid),
    .out_accept  (out_accept),
    .out_word    (out_word)
);

// File: tb/test_l0_veto_trigger.sv
`timescale 1ns/1ps
module test_l0_veto_trigger;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_hodo_cnt = '0;
    logic        in_muon_hit = 1'b0;
    logic [13:0] in_lav_mask = '0;
    logic [79:0] in_octant_energy = '0;
    logic        out_valid, out_accept;
    logic [5:0]  out_word;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    l0_veto_trigger i_l0_veto_trigger (
        .clk              (clk),
        .rst              (rst),
        .in_valid         (in_valid),
        .in_hodo_cnt      (in_hodo_cnt),
        .in_muon_hit      (in_muon_hit),
        .in_lav_mask      (in_lav_mask),
        .in_octant_energy (in_octant_energy),
        .out_valid        (out_valid),
        .out_accept       (out_accept),
        .out_word         (out_word)
    );

    typedef struct packed {
        logic [3:0]  hodo;
        logic        mu;
        logic [13:0] lav;
        logic [79:0] oct;
        logic [5:0]  exp_word;
    } vec_t;

    function automatic logic [79:0] oct8(int e0, int e1, int e2, int e3,
                                         int e4, int e5, int e6, int e7);
        return {10'(e7), 10'(e6), 10'(e5), 10'(e4),
                10'(e3), 10'(e2), 10'(e1), 10'(e0)};
    endfunction

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0, 14'h0000, oct8(0,0,0,0,0,0,0,0),                 6'h3F}, // all pass
        '{4'd0,  1'b0, 14'h0000, oct8(0,0,0,0,0,0,0,0),                 6'h3C}, // R1 R2 no hit
        '{4'd2,  1'b0, 14'h0000, oct8(0,0,0,0,0,0,0,0),                 6'h3D}, // R2 two hits
        '{4'd1,  1'b1, 14'h0000, oct8(0,0,0,0,0,0,0,0),                 6'h3B}, // R3 muon
        '{4'd1,  1'b0, 14'h2000, oct8(0,0,0,0,0,0,0,0),                 6'h37}, // R4 pocket 13
        '{4'd1,  1'b0, 14'h0001, oct8(0,0,0,0,0,0,0,0),                 6'h37}, // R4 pocket 0
        '{4'd1,  1'b0, 14'h0000, oct8(250,249,0,0,0,0,0,0),             6'h3F}, // R5 total 499
        '{4'd1,  1'b0, 14'h0000, oct8(250,250,0,0,0,0,0,0),             6'h2F}, // R5 total 500
        '{4'd1,  1'b0, 14'h0000, oct8(11,0,0,0,11,0,0,0),               6'h1F}, // R7 both fail
        '{4'd1,  1'b0, 14'h0000, oct8(0,11,11,0,0,0,0,0),               6'h3F}, // R7 only B passes
        '{4'd1,  1'b0, 14'h0000, oct8(11,11,0,0,0,0,0,0),               6'h3F}, // R7 only A passes
        '{4'd1,  1'b0, 14'h0000, oct8(10,0,0,0,10,0,0,0),               6'h3F}, // R6 sum 10 inactive
        '{4'd0,  1'b1, 14'h3FFF, oct8(100,100,100,100,100,100,100,100), 6'h00}, // all fail
        '{4'd15, 1'b0, 14'h0000, oct8(0,0,0,0,0,0,0,0),                 6'h3D}, // R2 max count
        '{4'd1,  1'b0, 14'h0000, oct8(6,6,0,0,0,0,0,0),                 6'h3F}  // R6 sums 12, pass
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(vec_t v, logic vld);
        in_valid         = vld;
        in_hodo_cnt      = v.hodo;
        in_muon_hit      = v.mu;
        in_lav_mask      = v.lav;
        in_octant_energy = v.oct;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: state after reset
        chk("R10 reset out_valid", 32'(out_valid), 0);
        chk("R10 reset out_word", 32'(out_word), 0);
        chk("R10 reset out_accept", 32'(out_accept), 0);
        rst = 1'b0;

        // Table walk, back-to-back candidates (R9 streaming).
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R9 streamed out_valid", 32'(out_valid), 1);
                chk("R1 R2 R3 R4 R5 R6 R7 word", 32'(out_word), 32'(VECS[i-2].exp_word));
                chk("R8 accept", 32'(out_accept), 32'(VECS[i-2].exp_word == 6'h3F));
            end
            if (i < NV) drive(VECS[i], 1'b1);
            else        drive(VECS[0], 1'b0);
        end

        // R11: idle with passing data on inputs but no valid.
        repeat (2) @(negedge clk);
        chk("R11 idle out_valid", 32'(out_valid), 0);
        chk("R11 idle word", 32'(out_word), 0);
        chk("R11 idle accept", 32'(out_accept), 0);

        // R9: a single pulse shows up exactly two edges later.
        drive(VECS[0], 1'b1);
        @(negedge clk);
        drive(VECS[0], 1'b0);
        chk("R9 one edge later", 32'(out_valid), 0);
        @(negedge clk);
        chk("R9 two edges later", 32'(out_valid), 1);
        chk("R9 pulse accept", 32'(out_accept), 1);
        @(negedge clk);
        chk("R9 three edges later", 32'(out_valid), 0);

        // R10: reset with a candidate in flight.
        drive(VECS[0], 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 flight out_valid", 32'(out_valid), 0);
        chk("R10 flight accept", 32'(out_accept), 0);
        chk("R10 flight word", 32'(out_word), 0);
        rst = 1'b0;
        drive(VECS[0], 1'b0);
        repeat (2) @(negedge clk);
        chk("R10 flushed out_valid", 32'(out_valid), 0);

        summary();
        $finish;
    end

endmodule